// File: doc/BRIEF.md
# Burst/Continuous I/Q Input Formatter

This block sits at the sample input of a quadrature transmitter. It accepts baseband data on one input bus and rebuilds it into paired I and Q words of 12 bits. The bus carries a full word per clock, a 6-bit piece per clock or a 3-bit piece per clock, chosen at run time. The incoming samples are taken to be already oversampled, so the block changes no rate: it only reassembles words and sorts them into channels.

A single transmit-enable input has two meanings, set by a mode setting. In burst mode its rising edge marks the first piece of a packet and resets all alignment. Words then alternate I, Q, I, Q while it stays high. If it drops in the middle of a word or pair, the partial data is thrown away and a sticky underrun flag is raised. In continuous mode data is taken on every clock, and the level of transmit-enable on a word's last piece sends that word to I (high) or Q (low). Each complete pair appears on the outputs together with a one-cycle valid pulse.

Top module: `iq_input_formatter`

## Requirements
- R1: With width code 0 (or the reserved code 3), every accepted cycle supplies one complete 12-bit word taken from din[11:0].
- R2: With width code 1, a word is built from two accepted cycles of din[5:0], most significant half first; din[11:6] is ignored.
- R3: With width code 2, a word is built from four accepted cycles of din[2:0], most significant piece first; din[11:3] is ignored.
- R4: In burst mode (cfg_continuous=0), data is accepted only in cycles with txen high. The first high cycle after a low one carries the first piece of an I word, and complete words then alternate I, Q.
- R5: When the last piece of a Q word is accepted and an I word is held, out_valid is high for exactly the following cycle. out_i and out_q show that pair and keep their values until the next pair.
- R6: In burst mode, a low txen cycle that finds a partial word or a held I word discards them and sets underrun. A drop after a complete pair leaves underrun unchanged.
- R7: underrun stays set until a clock edge with clr_underrun high. If a new discard happens on the same edge, the set wins.
- R8: In continuous mode (cfg_continuous=1), a piece is accepted every cycle. A completed word goes to I if txen is high on its last piece, and to Q if txen is low.
- R9: In continuous mode, a Q word pairs with the held I word and clears it. A Q word with no held I is dropped. A newer I word replaces the held one.
- R10: A new cfg_width or cfg_continuous value takes effect only in a cycle with txen low. That cycle's din is ignored, all partial and held state is cleared, and no underrun results in continuous mode. Changes made while txen is high are deferred.
- R11: After reset, out_valid, out_i, out_q and underrun are zero, and the active setting is 12-bit burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Requested bus width: 0 full, 1 half, 2 quarter, 3 full |
| cfg_continuous | input | 1 | Requested mode: 1 continuous, 0 burst |
| txen | input | 1 | Transmit enable: framing in burst, channel select in continuous |
| din | input | 12 | Input data or data piece, right-aligned |
| clr_underrun | input | 1 | Clears the underrun flag |
| out_i | output | 12 | I word of the last pair |
| out_q | output | 12 | Q word of the last pair |
| out_valid | output | 1 | One-cycle strobe for a new pair |
| underrun | output | 1 | Sticky flag for a burst cut short |

## Verification
A piece counter that is out of step shows up at once on the next pair as shifted or swapped bits in out_i or out_q. A stale held I word shows up as an extra or missing out_valid pulse on the next Q completion. Wrong alignment after a framing edge swaps I and Q in the first pair of the packet, which is within two to eight cycles of the edge. A mishandled setting change is seen on the first pair after the change, or on the underrun flag one cycle after the low txen cycle.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  parameter int unsigned IQF_WORD_W = 12;
  localparam int unsigned IQF_HALF_W = IQF_WORD_W / 2;
  localparam int unsigned IQF_QTR_W  = IQF_WORD_W / 4;

  typedef enum logic [1:0] {
    WIDTH_FULL    = 2'd0,
    WIDTH_HALF    = 2'd1,
    WIDTH_QUARTER = 2'd2,
    WIDTH_RSVD    = 2'd3
  } width_e;

  // index of the last piece of a word for a given bus width
  function automatic logic [1:0] last_piece(input width_e w);
    case (w)
      WIDTH_HALF:    return 2'd1;
      WIDTH_QUARTER: return 2'd3;
      default:       return 2'd0;
    endcase
  endfunction

  // shift the accumulated pieces up and append the new piece
  function automatic logic [IQF_WORD_W-1:0] pack_piece(
    input logic [IQF_WORD_W-1:0] acc,
    input logic [IQF_WORD_W-1:0] din,
    input width_e                w
  );
    case (w)
      WIDTH_HALF:    return {acc[IQF_WORD_W-IQF_HALF_W-1:0], din[IQF_HALF_W-1:0]};
      WIDTH_QUARTER: return {acc[IQF_WORD_W-IQF_QTR_W-1:0], din[IQF_QTR_W-1:0]};
      default:       return din;
    endcase
  endfunction
endpackage

// File: rtl/iqf_cfg_ctrl.sv
module iqf_cfg_ctrl
  import iqf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txen,
  input  logic [1:0] cfg_width,
  input  logic       cfg_continuous,
  output width_e     act_width,
  output logic       act_cont,
  output logic       cfg_chg
);
  logic differs;

  assign differs = (width_e'(cfg_width) != act_width) || (cfg_continuous != act_cont);
  assign cfg_chg = !txen && differs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_width <= WIDTH_FULL;
      act_cont  <= 1'b0;
    end else if (cfg_chg) begin
      act_width <= width_e'(cfg_width);
      act_cont  <= cfg_continuous;
    end
  end
endmodule

// File: rtl/iqf_piece_packer.sv
module iqf_piece_packer
  import iqf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  take,
  input  width_e                width,
  input  logic [IQF_WORD_W-1:0] din,
  output logic                  word_done,
  output logic [IQF_WORD_W-1:0] word,
  output logic                  partial
);
  logic [1:0]            piece_cnt;
  logic [IQF_WORD_W-1:0] acc;
  logic                  at_last;

  assign at_last   = (piece_cnt == last_piece(width));
  assign word      = pack_piece(acc, din, width);
  assign word_done = take && at_last;
  assign partial   = (piece_cnt != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      piece_cnt <= 2'd0;
      acc       <= '0;
    end else if (take) begin
      if (at_last) begin
        piece_cnt <= 2'd0;
        acc       <= '0;
      end else begin
        piece_cnt <= piece_cnt + 2'd1;
        acc       <= word;
      end
    end
  end
endmodule

// File: rtl/iqf_pair_builder.sv
module iqf_pair_builder
  import iqf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  burst,
  input  logic                  txen,
  input  logic                  word_done,
  input  logic [IQF_WORD_W-1:0] word,
  input  logic                  pk_partial,
  input  logic                  clr_underrun,
  output logic                  emit,
  output logic                  drop_partial,
  output logic [IQF_WORD_W-1:0] out_i,
  output logic [IQF_WORD_W-1:0] out_q,
  output logic                  out_valid,
  output logic                  underrun
);
  logic                  word_sel;
  logic                  have_i;
  logic [IQF_WORD_W-1:0] held_i;
  logic                  steer_i;

  assign steer_i      = burst ? !word_sel : txen;
  assign emit         = word_done && !steer_i && have_i;
  assign drop_partial = burst && !txen && (pk_partial || have_i);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      word_sel <= 1'b0;
      have_i   <= 1'b0;
    end else if (word_done) begin
      word_sel <= !word_sel;
      have_i   <= steer_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_i <= '0;
    else if (word_done && steer_i) held_i <= word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_i <= held_i;
        out_q <= word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (drop_partial) underrun <= 1'b1;
    else if (clr_underrun) underrun <= 1'b0;
  end
endmodule

// File: rtl/iq_input_formatter.sv
module iq_input_formatter
  import iqf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_width,
  input  logic                  cfg_continuous,
  input  logic                  txen,
  input  logic [IQF_WORD_W-1:0] din,
  input  logic                  clr_underrun,
  output logic [IQF_WORD_W-1:0] out_i,
  output logic [IQF_WORD_W-1:0] out_q,
  output logic                  out_valid,
  output logic                  underrun
);
  width_e                act_width;
  logic                  act_cont;
  logic                  cfg_chg;
  logic                  take;
  logic                  flush;
  logic                  word_done;
  logic [IQF_WORD_W-1:0] word;
  logic                  pk_partial;
  logic                  emit;
  logic                  drop_partial;

  assign take  = !cfg_chg && (act_cont || txen);
  assign flush = cfg_chg || (!act_cont && !txen);

  iqf_cfg_ctrl u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .txen           (txen),
    .cfg_width      (cfg_width),
    .cfg_continuous (cfg_continuous),
    .act_width      (act_width),
    .act_cont       (act_cont),
    .cfg_chg        (cfg_chg)
  );

  iqf_piece_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .take      (take),
    .width     (act_width),
    .din       (din),
    .word_done (word_done),
    .word      (word),
    .partial   (pk_partial)
  );

  iqf_pair_builder u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .burst        (!act_cont),
    .txen         (txen),
    .word_done    (word_done),
    .word         (word),
    .pk_partial   (pk_partial),
    .clr_underrun (clr_underrun),
    .emit         (emit),
    .drop_partial (drop_partial),
    .out_i        (out_i),
    .out_q        (out_q),
    .out_valid    (out_valid),
    .underrun     (underrun)
  );
endmodule

// File: rtl/iqf_checker.sv
module iqf_checker
  import iqf_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   txen,
  input logic   clr_underrun,
  input width_e act_width,
  input logic   act_cont,
  input logic   cfg_chg,
  input logic   emit,
  input logic   drop_partial,
  input logic   out_valid,
  input logic   underrun
);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_valid_from_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(emit));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_underrun) |=> underrun);

  p_drop_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_partial |=> underrun);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_cont && !txen) |=> !out_valid);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txen |=> ($stable(act_width) && $stable(act_cont)));

  p_chg_no_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !out_valid);
endmodule

bind iq_input_formatter iqf_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .txen         (txen),
  .clr_underrun (clr_underrun),
  .act_width    (act_width),
  .act_cont     (act_cont),
  .cfg_chg      (cfg_chg),
  .emit         (emit),
  .drop_partial (drop_partial),
  .out_valid    (out_valid),
  .underrun     (underrun)
);

// File: tb/iq_input_formatter_tb.sv
module iq_input_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        cfg_continuous = 1'b0;
  logic        txen = 1'b0;
  logic [11:0] din = '0;
  logic        clr_underrun = 1'b0;
  logic [11:0] out_i, out_q;
  logic        out_valid, underrun;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  iq_input_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_continuous(cfg_continuous),
    .txen(txen), .din(din), .clr_underrun(clr_underrun),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid), .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input logic [11:0] ei, input logic [11:0] eq);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " i"}, {20'd0, out_i}, {20'd0, ei});
    check({req, " q"}, {20'd0, out_q}, {20'd0, eq});
  endtask

  // drive one cycle; outputs afterwards reflect that edge
  task automatic drv(input logic t, input logic [11:0] d);
    txen = t;
    din  = d;
    @(posedge clk);
    #1;
  endtask

  // pieces per word from the width code, per R1..R3
  function automatic int pieces(input int wsel);
    return (wsel == 1) ? 2 : (wsel == 2) ? 4 : 1;
  endfunction

  // piece k of word w, junk ones placed above the piece
  function automatic logic [11:0] piece_of(input logic [11:0] w, input int wsel, input int k);
    int n = pieces(wsel);
    int b = 12 / n;
    logic [11:0] mask = (12'hFFF >> (12 - b));
    logic [11:0] p = (w >> (b * (n - 1 - k))) & mask;
    return (n == 1) ? w : (p | ~mask);
  endfunction

  task automatic send_word(input logic [11:0] w, input int wsel, input logic t);
    for (int k = 0; k < pieces(wsel); k++) drv(t, piece_of(w, wsel, k));
  endtask

  task automatic t_reset();
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 i", {20'd0, out_i}, 32'd0);
    check("R11 q", {20'd0, out_q}, 32'd0);
    check("R11 underrun", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_burst_full();
    drv(1, 12'hA11);
    check("R4 no pair after I", {31'd0, out_valid}, 32'd0);
    drv(1, 12'hB22);
    check_pair("R1 R5 pair1", 12'hA11, 12'hB22);
    drv(1, 12'hC33);
    check("R5 pulse one cycle", {31'd0, out_valid}, 32'd0);
    check("R5 i held", {20'd0, out_i}, 32'hA11);
    drv(1, 12'hD44);
    check_pair("R4 pair2", 12'hC33, 12'hD44);
    drv(0, 12'h0);
    check("R6 clean drop", {31'd0, underrun}, 32'd0);
    check("R5 q held", {20'd0, out_q}, 32'hD44);
  endtask

  task automatic t_underrun();
    drv(1, 12'h111);
    drv(0, 12'h0);
    check("R6 drop after I", {31'd0, underrun}, 32'd1);
    drv(0, 12'h0);
    check("R7 sticky", {31'd0, underrun}, 32'd1);
    drv(1, 12'h222);
    drv(1, 12'h333);
    check_pair("R4 realign", 12'h222, 12'h333);
    drv(1, 12'h444);
    clr_underrun = 1'b1;
    drv(0, 12'h0);
    check("R7 set beats clear", {31'd0, underrun}, 32'd1);
    drv(0, 12'h0);
    clr_underrun = 1'b0;
    check("R7 cleared", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_defer();
    cfg_width = 2'd1;
    drv(1, 12'h5A5);
    drv(1, 12'h6B6);
    check_pair("R10 deferred while high", 12'h5A5, 12'h6B6);
    drv(0, 12'h0);
    check("R10 change cycle quiet", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_burst_half();
    send_word(12'hABC, 1, 1);
    check("R2 no pair mid", {31'd0, out_valid}, 32'd0);
    send_word(12'h123, 1, 1);
    check_pair("R2 half pair", 12'hABC, 12'h123);
    drv(0, 12'h0);
    drv(1, piece_of(12'h777, 1, 0));
    drv(0, 12'h0);
    check("R6 drop mid word", {31'd0, underrun}, 32'd1);
    clr_underrun = 1'b1;
    drv(0, 12'h0);
    clr_underrun = 1'b0;
    check("R7 clear", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_burst_quarter();
    cfg_width = 2'd2;
    drv(0, 12'h0);
    send_word(12'h5A7, 2, 1);
    send_word(12'hE19, 2, 1);
    check_pair("R3 quarter pair", 12'h5A7, 12'hE19);
    send_word(12'h0F0, 2, 1);
    drv(0, 12'h0);
    check("R6 drop mid pair", {31'd0, underrun}, 32'd1);
    clr_underrun = 1'b1;
    drv(0, 12'h0);
    clr_underrun = 1'b0;
  endtask

  task automatic t_continuous();
    cfg_width = 2'd0;
    cfg_continuous = 1'b1;
    drv(0, 12'h0);
    drv(1, 12'h0A0);
    drv(0, 12'h0B0);
    check_pair("R8 steer by level", 12'h0A0, 12'h0B0);
    drv(0, 12'h0C0);
    check("R9 lone Q dropped", {31'd0, out_valid}, 32'd0);
    drv(1, 12'h0D0);
    drv(1, 12'h0E0);
    drv(0, 12'h0F0);
    check_pair("R9 newer I replaces", 12'h0E0, 12'h0F0);
    drv(1, 12'h777);
    cfg_width = 2'd1;
    drv(0, 12'h999);
    check("R10 change cycle ignored", {31'd0, out_valid}, 32'd0);
    send_word(12'h456, 1, 0);
    check("R10 held I cleared", {31'd0, out_valid}, 32'd0);
    drv(0, piece_of(12'h321, 1, 0));
    drv(1, piece_of(12'h321, 1, 1));
    send_word(12'h654, 1, 0);
    check_pair("R8 last piece decides", 12'h321, 12'h654);
    check("R10 no underrun", {31'd0, underrun}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_burst_full();
    t_underrun();
    t_defer();
    t_burst_half();
    t_burst_quarter();
    t_continuous();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule